// File: doc/BRIEF.md
# Integer extend and subtract unit

This block is one execution stage of a 32-bit register machine. It decodes a 16-bit instruction word and performs one of nine integer operations on two source register values, Rm and Rn. The operations fall into three groups. Extension widens a byte or a halfword of Rm to full width, either signed or unsigned. Negation computes zero minus Rm, with or without a borrow-in. Subtraction computes Rn minus Rm in three forms: plain, with borrow, and with signed-underflow detection. A single flag bit, T, is the borrow-in, the borrow-out and the underflow flag. Only the borrow and underflow forms change it.

An instruction is presented with `op_valid` high, together with the operand values and the current T. The result appears on the outputs one clock later. The outputs are a destination value, a destination index, a register write enable, the next T value, a T write enable, and an illegal-opcode flag. A two-state controller tracks whether the output stage holds a result. In state ST_EMPTY no result is held. The transition "accept" (op_valid high) moves it to ST_HOLD. The transition "drain" (op_valid low) returns it to ST_EMPTY. The transition "chain" (op_valid high in ST_HOLD) stays in ST_HOLD with a new result. Reset forces ST_EMPTY.

Top module: `xsu_top`

## Requirements
- R1: Instruction words 0x6nmE and 0x6nmF give Rm's low byte and Rm's low halfword, each sign-extended to 32 bits, with res_we high and t_we low.
- R2: Instruction words 0x6nmC and 0x6nmD give Rm's low byte and Rm's low halfword, each zero-extended to 32 bits, with res_we high and t_we low.
- R3: Instruction word 0x6nmB gives 0 − Rm, and t_we stays low.
- R4: Instruction word 0x6nmA gives 0 − Rm − T, sets t_we, and drives t_next to the borrow. The borrow is 1 when Rm + T, taken as unsigned, exceeds 0.
- R5: Instruction word 0x3nm8 gives Rn − Rm, and t_we stays low.
- R6: Instruction word 0x3nmA gives Rn − Rm − T, sets t_we, and drives t_next to the borrow. The borrow is 1 when Rm + T, taken as unsigned, exceeds unsigned Rn.
- R7: Instruction word 0x3nmB gives Rn − Rm, sets t_we, and drives t_next to the signed underflow. Underflow is 1 when Rn and Rm differ in bit 31 and the result's bit 31 differs from Rn's.
- R8: res_dst equals instruction bits 11:8. All outputs reflect the instruction accepted at the previous clock edge.
- R9: For any valid word outside the patterns in R1 to R7, illegal is 1 and both res_we and t_we are 0.
- R10: A cycle with op_valid low produces res_we, t_we and illegal all 0 at the next edge.
- R11: After reset, res_val, res_dst, res_we, t_we, illegal and t_next are all 0.
- R12: Whenever t_we is 0 after an accepted instruction, t_next equals the T input that came with that instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Instruction word and operands present |
| instr | input | 16 | Instruction word |
| rm_val | input | 32 | Value of source register Rm |
| rn_val | input | 32 | Value of register Rn |
| t_in | input | 1 | Current T flag |
| res_val | output | 32 | Destination value |
| res_dst | output | 4 | Destination register index |
| res_we | output | 1 | Destination write enable |
| t_next | output | 1 | Next T value |
| t_we | output | 1 | T write enable |
| illegal | output | 1 | Unrecognised instruction word |

## Verification
The assertions assume that `instr`, `t_in` and `op_valid` are known, not X, at each rising edge after reset. They also assume that the previous-cycle checks refer only to cycles after reset has been released. The checker tracks this with its own flag that is set after reset. The bench drives every input from tasks on the falling clock edge, so the inputs are stable at each rising edge. It holds `op_valid` low whenever no scenario is issuing an instruction. Operand values are picked to reach the sign, borrow and underflow boundaries of each operation.

// File: rtl/xsu_pkg.sv
package xsu_pkg;

    localparam int XLEN    = 32;
    localparam int INSTR_W = 16;
    localparam int RIDX_W  = 4;

    typedef enum logic [3:0] {
        OP_NONE = 4'd0,
        OP_SXB  = 4'd1,
        OP_SXH  = 4'd2,
        OP_ZXB  = 4'd3,
        OP_ZXH  = 4'd4,
        OP_NEG  = 4'd5,
        OP_NEGB = 4'd6,
        OP_SUB  = 4'd7,
        OP_SUBB = 4'd8,
        OP_SUBU = 4'd9
    } xsu_op_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_HOLD  = 1'b1
    } xsu_state_e;

endpackage

// File: rtl/xsu_decode.sv
module xsu_decode
    import xsu_pkg::*;
#(
    parameter int IW = INSTR_W,
    parameter int RW = RIDX_W
) (
    input  logic [IW-1:0] instr,
    output xsu_op_e       op,
    output logic [RW-1:0] dst_idx,
    output logic          legal
);
    localparam int HI_LSB = IW - 4;
    localparam int RN_LSB = 8;

    logic [3:0] hi_nib;
    logic [3:0] lo_nib;

    assign hi_nib  = instr[IW-1:HI_LSB];
    assign lo_nib  = instr[3:0];
    assign dst_idx = instr[RN_LSB+RW-1:RN_LSB];

    always_comb begin
        op = OP_NONE;
        unique case (hi_nib)
            4'b0110: begin
                unique case (lo_nib)
                    4'b1110: op = OP_SXB;
                    4'b1111: op = OP_SXH;
                    4'b1100: op = OP_ZXB;
                    4'b1101: op = OP_ZXH;
                    4'b1011: op = OP_NEG;
                    4'b1010: op = OP_NEGB;
                    default: op = OP_NONE;
                endcase
            end
            4'b0011: begin
                unique case (lo_nib)
                    4'b1000: op = OP_SUB;
                    4'b1010: op = OP_SUBB;
                    4'b1011: op = OP_SUBU;
                    default: op = OP_NONE;
                endcase
            end
            default: op = OP_NONE;
        endcase
    end

    assign legal = (op != OP_NONE);

endmodule

// File: rtl/xsu_extend.sv
module xsu_extend
    import xsu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  xsu_op_e      op,
    input  logic [W-1:0] src,
    output logic [W-1:0] ext
);
    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;

    always_comb begin
        unique case (op)
            OP_SXB:  ext = {{(W-BYTE_W){src[BYTE_W-1]}}, src[BYTE_W-1:0]};
            OP_SXH:  ext = {{(W-HALF_W){src[HALF_W-1]}}, src[HALF_W-1:0]};
            OP_ZXB:  ext = {{(W-BYTE_W){1'b0}}, src[BYTE_W-1:0]};
            OP_ZXH:  ext = {{(W-HALF_W){1'b0}}, src[HALF_W-1:0]};
            default: ext = '0;
        endcase
    end

endmodule

// File: rtl/xsu_subtract.sv
module xsu_subtract
    import xsu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] minuend,
    input  logic [W-1:0] subtrahend,
    input  logic         borrow_in,
    output logic [W-1:0] diff,
    output logic         borrow_out,
    output logic         underflow
);
    logic [W:0] wide;

    assign wide       = {1'b0, minuend} - {1'b0, subtrahend} - {{W{1'b0}}, borrow_in};
    assign diff       = wide[W-1:0];
    assign borrow_out = wide[W];
    assign underflow  = (minuend[W-1] != subtrahend[W-1]) && (wide[W-1] != minuend[W-1]);

endmodule

// File: rtl/xsu_top.sv
module xsu_top
    import xsu_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    input  logic [INSTR_W-1:0]  instr,
    input  logic [XLEN-1:0]     rm_val,
    input  logic [XLEN-1:0]     rn_val,
    input  logic                t_in,
    output logic [XLEN-1:0]     res_val,
    output logic [RIDX_W-1:0]   res_dst,
    output logic                res_we,
    output logic                t_next,
    output logic                t_we,
    output logic                illegal
);
    xsu_op_e             op;
    logic [RIDX_W-1:0]   dst_idx;
    logic                legal;
    logic [XLEN-1:0]     ext_res;
    logic [XLEN-1:0]     sub_min;
    logic                sub_bin;
    logic [XLEN-1:0]     sub_res;
    logic                sub_borrow;
    logic                sub_uflow;
    logic [XLEN-1:0]     res_d;
    logic                flag_upd_d;
    logic                flag_val_d;

    xsu_state_e          state_q, state_d;
    logic [XLEN-1:0]     res_q;
    logic [RIDX_W-1:0]   dst_q;
    logic                legal_q;
    logic                flag_upd_q;
    logic                flag_val_q;

    xsu_decode #(.IW(INSTR_W), .RW(RIDX_W)) i_dec (
        .instr   (instr),
        .op      (op),
        .dst_idx (dst_idx),
        .legal   (legal)
    );

    xsu_extend #(.W(XLEN)) i_ext (
        .op  (op),
        .src (rm_val),
        .ext (ext_res)
    );

    always_comb begin
        sub_min = rn_val;
        sub_bin = 1'b0;
        unique case (op)
            OP_NEG:  sub_min = '0;
            OP_NEGB: begin sub_min = '0; sub_bin = t_in; end
            OP_SUBB: sub_bin = t_in;
            default: ;
        endcase
    end

    xsu_subtract #(.W(XLEN)) i_sub (
        .minuend    (sub_min),
        .subtrahend (rm_val),
        .borrow_in  (sub_bin),
        .diff       (sub_res),
        .borrow_out (sub_borrow),
        .underflow  (sub_uflow)
    );

    always_comb begin
        res_d      = '0;
        flag_upd_d = 1'b0;
        flag_val_d = t_in;
        unique case (op)
            OP_SXB, OP_SXH, OP_ZXB, OP_ZXH: res_d = ext_res;
            OP_NEG, OP_SUB:                 res_d = sub_res;
            OP_NEGB, OP_SUBB: begin
                res_d      = sub_res;
                flag_upd_d = 1'b1;
                flag_val_d = sub_borrow;
            end
            OP_SUBU: begin
                res_d      = sub_res;
                flag_upd_d = 1'b1;
                flag_val_d = sub_uflow;
            end
            default: ;
        endcase
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (op_valid)  state_d = ST_HOLD;   // accept
            ST_HOLD:  if (!op_valid) state_d = ST_EMPTY;  // drain (else chain)
            default:  state_d = ST_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // result stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q      <= '0;
            dst_q      <= '0;
            legal_q    <= 1'b0;
            flag_upd_q <= 1'b0;
            flag_val_q <= 1'b0;
        end else if (op_valid) begin
            res_q      <= res_d;
            dst_q      <= dst_idx;
            legal_q    <= legal;
            flag_upd_q <= flag_upd_d;
            flag_val_q <= flag_val_d;
        end
    end

    // outputs
    always_comb begin
        res_val = res_q;
        res_dst = dst_q;
        t_next  = flag_val_q;
        res_we  = 1'b0;
        t_we    = 1'b0;
        illegal = 1'b0;
        unique case (state_q)
            ST_HOLD: begin
                res_we  = legal_q;
                t_we    = legal_q && flag_upd_q;
                illegal = !legal_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/xsu_checker.sv
module xsu_checker
    import xsu_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                op_valid,
    input logic [INSTR_W-1:0]  instr,
    input logic                t_in,
    input logic [RIDX_W-1:0]   res_dst,
    input logic                res_we,
    input logic                t_next,
    input logic                t_we,
    input logic                illegal
);
    logic past_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!res_we && !t_we)); // R9

    AST_WE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({res_we, illegal})); // R9

    AST_FLAG_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        t_we |-> res_we); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(op_valid)) |-> (!res_we && !t_we && !illegal)); // R10

    AST_DST_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && res_we) |-> (res_dst == $past(instr[11:8]))); // R8

    AST_T_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(op_valid) && !t_we) |-> (t_next == $past(t_in))); // R12

    AST_NEG_KEEPS_T: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(op_valid) && ($past(instr[15:12]) == 4'b0110)
         && ($past(instr[3:0]) == 4'b1011)) |-> !t_we); // R3

endmodule

bind xsu_top xsu_checker i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .instr    (instr),
    .t_in     (t_in),
    .res_dst  (res_dst),
    .res_we   (res_we),
    .t_next   (t_next),
    .t_we     (t_we),
    .illegal  (illegal)
);

// File: tb/test_xsu_top.sv
`timescale 1ns/1ps
module test_xsu_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [15:0] instr = '0;
    logic [31:0] rm_val = '0;
    logic [31:0] rn_val = '0;
    logic        t_in = 1'b0;
    logic [31:0] res_val;
    logic [3:0]  res_dst;
    logic        res_we;
    logic        t_next;
    logic        t_we;
    logic        illegal;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    xsu_top i_xsu_top (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .instr(instr),
        .rm_val(rm_val), .rn_val(rn_val), .t_in(t_in),
        .res_val(res_val), .res_dst(res_dst), .res_we(res_we),
        .t_next(t_next), .t_we(t_we), .illegal(illegal)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // issue one instruction and sample the registered result
    task automatic issue(input logic [15:0] ins, input logic [31:0] rm,
                         input logic [31:0] rn, input logic t);
        @(negedge clk);
        op_valid = 1'b1; instr = ins; rm_val = rm; rn_val = rn; t_in = t;
        @(posedge clk);
        #1;
        op_valid = 1'b0;
    endtask

    // expected difference and borrow, from R4/R6 definition
    function automatic logic [32:0] ref_sub(input logic [31:0] a, input logic [31:0] b, input logic c);
        logic [32:0] r;
        r[31:0] = a - b - {31'b0, c};
        r[32]   = ({1'b0, b} + {32'b0, c}) > {1'b0, a};
        return r;
    endfunction

    task automatic t_reset;
        check("R11 res_val", res_val, 0);
        check("R11 res_dst", {28'b0, res_dst}, 0);
        check("R11 flags", {28'b0, res_we, t_we, illegal, t_next}, 0);
    endtask

    task automatic t_extend;
        issue(16'h612E, 32'h1234_5680, 32'h0, 1'b0);
        check("R1 sxb neg", res_val, 32'hFFFF_FF80);
        check("R1 we", {30'b0, res_we, t_we}, 32'h2);
        check("R8 dst", {28'b0, res_dst}, 32'h1);
        issue(16'h634E, 32'hAAAA_007F, 32'h0, 1'b1);
        check("R1 sxb pos", res_val, 32'h0000_007F);
        check("R12 t pass", {31'b0, t_next}, 1);
        issue(16'h6F0F, 32'h0001_8001, 32'h0, 1'b0);
        check("R1 sxh neg", res_val, 32'hFFFF_8001);
        check("R8 dst F", {28'b0, res_dst}, 32'hF);
    endtask

    task automatic t_zero;
        issue(16'h652C, 32'hFFFF_FFF0, 32'h0, 1'b0);
        check("R2 zxb", res_val, 32'h0000_00F0);
        issue(16'h652D, 32'hFFFF_8123, 32'h0, 1'b1);
        check("R2 zxh", res_val, 32'h0000_8123);
        check("R2 no t", {31'b0, t_we}, 0);
    endtask

    task automatic t_neg;
        issue(16'h621B, 32'h0000_0001, 32'h55, 1'b1);
        check("R3 neg", res_val, 32'hFFFF_FFFF);
        check("R3 t kept", {30'b0, t_we, t_next}, 32'h1);
        issue(16'h621B, 32'h8000_0000, 32'h0, 1'b0);
        check("R3 neg min", res_val, 32'h8000_0000);
    endtask

    task automatic t_negc;
        logic [32:0] e;
        e = ref_sub(32'h0, 32'h0, 1'b0);
        issue(16'h643A, 32'h0, 32'h9, 1'b0);
        check("R4 zero", res_val, e[31:0]);
        check("R4 borrow0", {30'b0, t_we, t_next}, {30'b0, 1'b1, e[32]});
        e = ref_sub(32'h0, 32'h0, 1'b1);
        issue(16'h643A, 32'h0, 32'h9, 1'b1);
        check("R4 t in", res_val, e[31:0]);
        check("R4 borrow1", {31'b0, t_next}, {31'b0, e[32]});
        e = ref_sub(32'h0, 32'h7, 1'b0);
        issue(16'h643A, 32'h7, 32'h9, 1'b0);
        check("R4 rm", {t_next, res_val[30:0]}, {e[32], e[30:0]});
    endtask

    task automatic t_sub;
        issue(16'h3758, 32'h3, 32'h5, 1'b1);
        check("R5 sub", res_val, 32'h2);
        check("R5 no t", {30'b0, t_we, t_next}, 32'h1);
        issue(16'h3758, 32'h5, 32'h3, 1'b0);
        check("R5 wrap", res_val, 32'hFFFF_FFFE);
    endtask

    task automatic t_subc;
        logic [32:0] e;
        e = ref_sub(32'h5, 32'h3, 1'b1);
        issue(16'h312A, 32'h3, 32'h5, 1'b1);
        check("R6 val", res_val, e[31:0]);
        check("R6 nb", {30'b0, t_we, t_next}, {30'b0, 1'b1, e[32]});
        e = ref_sub(32'h3, 32'h3, 1'b1);
        issue(16'h312A, 32'h3, 32'h3, 1'b1);
        check("R6 eq", res_val, e[31:0]);
        check("R6 b", {31'b0, t_next}, {31'b0, e[32]});
        e = ref_sub(32'h0, 32'hFFFF_FFFF, 1'b1);
        issue(16'h312A, 32'hFFFF_FFFF, 32'h0, 1'b1);
        check("R6 max", {t_next, res_val}, {e[32], e[31:0]});
    endtask

    task automatic t_subv;
        issue(16'h3ABB, 32'h1, 32'h8000_0000, 1'b0);
        check("R7 under", res_val, 32'h7FFF_FFFF);
        check("R7 t1", {30'b0, t_we, t_next}, 32'h3);
        issue(16'h3ABB, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 1'b0);
        check("R7 over", {t_next, res_val}, {1'b1, 32'h8000_0000});
        issue(16'h3ABB, 32'h3, 32'h5, 1'b1);
        check("R7 none", {30'b0, t_we, t_next}, 32'h2);
    endtask

    task automatic t_illegal;
        issue(16'h6A10, 32'h1, 32'h2, 1'b1);
        check("R9 6x0", {29'b0, res_we, t_we, illegal}, 32'h1);
        issue(16'h3129, 32'h1, 32'h2, 1'b0);
        check("R9 3x9", {29'b0, res_we, t_we, illegal}, 32'h1);
        issue(16'hF00E, 32'h1, 32'h2, 1'b0);
        check("R9 top", {29'b0, res_we, t_we, illegal}, 32'h1);
    endtask

    task automatic t_idle;
        issue(16'h312A, 32'h0, 32'h0, 1'b1);
        @(negedge clk);
        instr = 16'h312A;
        @(posedge clk); #1;
        check("R10 idle", {29'b0, res_we, t_we, illegal}, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset;
        @(negedge clk);
        rst_n = 1'b1;
        t_extend;
        t_zero;
        t_neg;
        t_negc;
        t_sub;
        t_subc;
        t_subv;
        t_illegal;
        t_idle;
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule